// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This block sits beside a small 8-bit CPU core and decides when a pending interrupt is taken. It watches the core's master interrupt enable, its 8-bit interrupt-enable register and its 8-bit interrupt-flag register. When a qualifying request is present, it pushes the current 16-bit program counter onto the stack as two byte writes through a simple request/acknowledge memory port. It then hands the core a single-cycle bundle of effects: the new stack pointer, the handler vector for the new program counter, a clear for the master enable, a one-hot clear for the serviced flag bit and a cycle-cost increment.

Four sources are recognised: a frame-blank source on flag bit 0, a display-status source on bit 1, a timer source on bit 2 and a keypad source on bit 4. When dispatch starts, the lowest-numbered pending source wins. The display-status source alone never starts a dispatch. It is serviced only when it is the highest-priority candidate at a moment when one of the other three sources is also pending. The source, vector and stack address are latched when dispatch starts, so flag changes during the stack push do not alter the outcome.

Top module: `irq_dispatch`

## Requirements
- R1: While `ime_i` is 0, no dispatch starts: `busy_o` and `mem_req_o` stay 0.
- R2: The candidate set is `ien_i & iflag_i`. Dispatch starts only if the candidate set has bit 0, bit 2 or bit 4 set. A candidate set with only bit 1 set, or only bits 3, 5, 6 or 7 set, leaves `busy_o` at 0.
- R3: The serviced source is the first candidate in the order bit 0, bit 1, bit 2, bit 4. For example, the candidate set 0x06 services bit 1.
- R4: The unit issues exactly two byte writes in this order: `pc_i[7:0]` to address `sp_i-2`, then `pc_i[15:8]` to address `sp_i-1`. The address is 16 bits and wraps modulo 2^16.
- R5: With `done_o`, `sp_o` equals `sp_i-2` modulo 2^16, using `sp_i` as sampled when dispatch starts.
- R6: With `done_o`, `pc_o` is the vector of the serviced source: 0x0040 for bit 0, 0x0048 for bit 1, 0x0050 for bit 2 and 0x0060 for bit 4.
- R7: `ime_clr_o` and `flag_clr_o` are nonzero only in the `done_o` cycle. There, `ime_clr_o` is 1 and `flag_clr_o` has exactly the serviced bit set.
- R8: `busy_o` is 1 from the cycle after dispatch starts through the `done_o` cycle. `done_o` lasts one cycle. `cyc_inc_o` is 3 in that cycle and 0 otherwise.
- R9: During reset, `busy_o`, `done_o` and `mem_req_o` are 0.
- R10: While `mem_req_o` is 1 and `mem_ack_i` is 0, the request, its address and its data hold unchanged into the next cycle.
- R11: The serviced source and vector are fixed when dispatch starts. A flag raised during the stack push does not change `pc_o` or `flag_clr_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ime_i | input | 1 | Master interrupt enable |
| ien_i | input | 8 | Interrupt-enable register |
| iflag_i | input | 8 | Interrupt-flag register |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| mem_req_o | output | 1 | Byte write request |
| mem_addr_o | output | 16 | Byte write address |
| mem_wdata_o | output | 8 | Byte write data |
| mem_ack_i | input | 1 | Write acknowledge; the byte is taken at the edge where request and acknowledge are both 1 |
| busy_o | output | 1 | Dispatch in progress |
| done_o | output | 1 | One-cycle completion strobe |
| pc_o | output | 16 | Handler vector, valid with done_o |
| sp_o | output | 16 | New stack pointer, valid with done_o |
| ime_clr_o | output | 1 | Clear master enable, with done_o |
| flag_clr_o | output | 8 | One-hot clear of the serviced flag bit |
| cyc_inc_o | output | 4 | Cycle-cost increment, 3 with done_o |

## Verification
The selection of a source can coincide with the arrival of a new request while the stack push is still waiting for the memory. This is provoked by holding off the acknowledge on the first byte and raising a higher-priority flag bit during that stall. The result is judged by requiring that the vector and the one-hot clear still belong to the source chosen when dispatch started. A second overlap comes from the display-status source being pending together with the timer. In that case the display-status source must win the priority pick, even though on its own it would not start a dispatch.

// File: rtl/irq_dispatch_pkg.sv
`timescale 1ns/1ps
package irq_dispatch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_DONE = 2'd2
  } disp_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
// Maps candidate bits onto sources, decides whether dispatch may start,
// and selects the lowest-index source with its vector and clear mask.
module irq_prio_pick #(
  parameter int W  = 8,
  parameter int NS = 4,
  parameter int AW = 16,
  parameter int PW = $clog2(W),
  parameter logic [NS*PW-1:0] SRC_POS  = {3'd4, 3'd2, 3'd1, 3'd0},
  parameter logic [NS-1:0]    SRC_TRIG = 4'b1101,
  parameter logic [NS*AW-1:0] SRC_VEC  = {16'h0060, 16'h0050, 16'h0048, 16'h0040}
) (
  input  logic [W-1:0]  cand_i,
  output logic          go_o,
  output logic [AW-1:0] vec_o,
  output logic [W-1:0]  clr_o
);
  logic [NS-1:0] hit;

  for (genvar i = 0; i < NS; i++) begin : g_hit
    assign hit[i] = cand_i[SRC_POS[i*PW +: PW]];
  end

  // R2: only trigger-capable sources may start a dispatch
  assign go_o = |(hit & SRC_TRIG);

  // R3: lowest index wins, so scan from the top and let lower hits override
  always_comb begin
    vec_o = '0;
    clr_o = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        vec_o = SRC_VEC[i*AW +: AW];
        clr_o = '0;
        clr_o[SRC_POS[i*PW +: PW]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_stack_wr.sv
`timescale 1ns/1ps
// Writes a two-byte word, low byte first, through a request/acknowledge port.
module irq_stack_wr #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [2*DW-1:0] word_i,
  input  logic          mem_ack_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          fin_o
);
  logic          active_q;
  logic          hi_q;
  logic [DW-1:0] hi_byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q    <= 1'b0;
      hi_q        <= 1'b0;
      hi_byte_q   <= '0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else if (start_i && !active_q) begin
      active_q    <= 1'b1;
      hi_q        <= 1'b0;
      mem_addr_o  <= base_i;
      mem_wdata_o <= word_i[DW-1:0];
      hi_byte_q   <= word_i[2*DW-1:DW];
    end else if (active_q && mem_ack_i) begin
      if (!hi_q) begin
        hi_q        <= 1'b1;
        mem_addr_o  <= mem_addr_o + AW'(1);
        mem_wdata_o <= hi_byte_q;
      end else begin
        active_q <= 1'b0;
        hi_q     <= 1'b0;
      end
    end
  end

  assign mem_req_o = active_q;
  assign fin_o     = active_q & hi_q & mem_ack_i;
endmodule

// File: rtl/irq_dispatch.sv
`timescale 1ns/1ps
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int W        = 8,
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int NS       = 4,
  parameter int CW       = 4,
  parameter int CYC_COST = 3,
  parameter int PW       = $clog2(W),
  parameter logic [NS*PW-1:0] SRC_POS  = {3'd4, 3'd2, 3'd1, 3'd0},
  parameter logic [NS-1:0]    SRC_TRIG = 4'b1101,
  parameter logic [NS*AW-1:0] SRC_VEC  = {16'h0060, 16'h0050, 16'h0048, 16'h0040}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ime_i,
  input  logic [W-1:0]  ien_i,
  input  logic [W-1:0]  iflag_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sp_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o,
  output logic          ime_clr_o,
  output logic [W-1:0]  flag_clr_o,
  output logic [CW-1:0] cyc_inc_o
);
  localparam int PUSH_BYTES = AW / DW;

  disp_state_e   state_q;
  logic          pick_go;
  logic [AW-1:0] pick_vec;
  logic [W-1:0]  pick_clr;
  logic          start;
  logic          push_fin;
  logic [AW-1:0] sp_new;
  logic [AW-1:0] vec_q;
  logic [AW-1:0] sp_q;
  logic [W-1:0]  clr_q;

  irq_prio_pick #(
    .W(W), .NS(NS), .AW(AW), .PW(PW),
    .SRC_POS(SRC_POS), .SRC_TRIG(SRC_TRIG), .SRC_VEC(SRC_VEC)
  ) u_pick (
    .cand_i (ien_i & iflag_i),
    .go_o   (pick_go),
    .vec_o  (pick_vec),
    .clr_o  (pick_clr)
  );

  assign start  = (state_q == ST_IDLE) && ime_i && pick_go;
  assign sp_new = sp_i - AW'(PUSH_BYTES);

  irq_stack_wr #(.AW(AW), .DW(DW)) u_push (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start),
    .base_i      (sp_new),
    .word_i      (pc_i),
    .mem_ack_i   (mem_ack_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .fin_o       (push_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      vec_q      <= '0;
      sp_q       <= '0;
      clr_q      <= '0;
      done_o     <= 1'b0;
      ime_clr_o  <= 1'b0;
      flag_clr_o <= '0;
      cyc_inc_o  <= '0;
      pc_o       <= '0;
      sp_o       <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_PUSH;
            vec_q   <= pick_vec;
            sp_q    <= sp_new;
            clr_q   <= pick_clr;
          end
        end
        ST_PUSH: begin
          if (push_fin) begin
            state_q    <= ST_DONE;
            done_o     <= 1'b1;
            ime_clr_o  <= 1'b1;
            flag_clr_o <= clr_q;
            cyc_inc_o  <= CW'(CYC_COST);
            pc_o       <= vec_q;
            sp_o       <= sp_q;
          end
        end
        default: begin
          state_q    <= ST_IDLE;
          done_o     <= 1'b0;
          ime_clr_o  <= 1'b0;
          flag_clr_o <= '0;
          cyc_inc_o  <= '0;
        end
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/irq_dispatch_chk.sv
`timescale 1ns/1ps
module irq_dispatch_chk #(
  parameter int W  = 8,
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 4,
  parameter logic [W-1:0] TRIG_MASK = 8'h15
) (
  input logic          clk,
  input logic          rst,
  input logic          ime_i,
  input logic [W-1:0]  ien_i,
  input logic [W-1:0]  iflag_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          ime_clr_o,
  input logic [W-1:0]  flag_clr_o,
  input logic [CW-1:0] cyc_inc_o
);
  // R1
  no_ime_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !ime_i) |=> !busy_o);

  // R2
  no_trigger_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && ((ien_i & iflag_i & TRIG_MASK) == '0)) |=> !busy_o);

  // R7
  clear_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ime_clr_o && $countones(flag_clr_o) == 1));

  // R7
  clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (!ime_clr_o && flag_clr_o == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  cost_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_inc_o != '0) |-> done_o);

  // R8
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> busy_o);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));
endmodule

bind irq_dispatch irq_dispatch_chk #(.W(W), .AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ime_i       (ime_i),
  .ien_i       (ien_i),
  .iflag_i     (iflag_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ime_clr_o   (ime_clr_o),
  .flag_clr_o  (flag_clr_o),
  .cyc_inc_o   (cyc_inc_o)
);

// File: tb/irq_dispatch_tb.sv
`timescale 1ns/1ps
module irq_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ime_i = 1'b0;
  logic [7:0]  ien_i = '0;
  logic [7:0]  iflag_i = '0;
  logic [15:0] pc_i = '0;
  logic [15:0] sp_i = '0;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic        busy_o;
  logic        done_o;
  logic [15:0] pc_o;
  logic [15:0] sp_o;
  logic        ime_clr_o;
  logic [7:0]  flag_clr_o;
  logic [3:0]  cyc_inc_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_dispatch u_dut (
    .clk(clk), .rst(rst), .ime_i(ime_i), .ien_i(ien_i), .iflag_i(iflag_i),
    .pc_i(pc_i), .sp_i(sp_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .busy_o(busy_o),
    .done_o(done_o), .pc_o(pc_o), .sp_o(sp_o), .ime_clr_o(ime_clr_o),
    .flag_clr_o(flag_clr_o), .cyc_inc_o(cyc_inc_o)
  );

  task automatic check(input string tag, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Source index of the winning candidate: 0..3, or -1 if none
  function automatic int pick_src(input logic [7:0] c);
    if (c[0]) return 0;
    if (c[1]) return 1;
    if (c[2]) return 2;
    if (c[4]) return 3;
    return -1;
  endfunction

  function automatic logic [15:0] src_vec(input int s);
    case (s)
      0: return 16'h0040;
      1: return 16'h0048;
      2: return 16'h0050;
      default: return 16'h0060;
    endcase
  endfunction

  function automatic logic [7:0] src_mask(input int s);
    case (s)
      0: return 8'h01;
      1: return 8'h02;
      2: return 8'h04;
      default: return 8'h10;
    endcase
  endfunction

  task automatic run_case(input string tag, input logic ime, input logic [7:0] en,
                          input logic [7:0] fl, input logic [15:0] pc,
                          input logic [15:0] sp, input int ackpct,
                          input logic [7:0] late);
    logic [7:0]  cand;
    int          sel;
    logic        go;
    logic [15:0] waddr [2];
    logic [7:0]  wdat [2];
    int          wn;
    logic        stall_prev;
    logic [15:0] hold_addr;
    logic [7:0]  hold_data;
    int          hold_err;
    int          busy_err;
    logic        seen_done;
    logic        give;
    logic [15:0] exp_sp;
    @(negedge clk);
    ime_i = ime; ien_i = en; iflag_i = fl; pc_i = pc; sp_i = sp; mem_ack_i = 1'b0;
    cand = en & fl;
    sel  = pick_src(cand);
    go   = ime && ((cand & 8'h15) != 8'h00);
    wn = 0; stall_prev = 1'b0; hold_err = 0; busy_err = 0; seen_done = 1'b0;
    hold_addr = '0; hold_data = '0;
    waddr[0] = '0; waddr[1] = '0; wdat[0] = '0; wdat[1] = '0;
    exp_sp = sp - 16'd2;
    if (!go) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (busy_o || mem_req_o) busy_err++;
      end
      check({tag, " no dispatch"}, busy_err == 0, busy_err, 0);
      ime_i = 1'b0;
    end else begin
      for (int t = 0; t < 80 && !seen_done; t++) begin
        @(negedge clk);
        if (stall_prev && (!mem_req_o || mem_addr_o != hold_addr || mem_wdata_o != hold_data))
          hold_err++;
        if (late != 8'h00 && busy_o) iflag_i = fl | late;
        if (done_o) begin
          seen_done = 1'b1;
          mem_ack_i = 1'b0;
        end else if (mem_req_o) begin
          if (!busy_o) busy_err++;
          give = (t == 0) ? 1'b0 : (int'($urandom_range(99)) < ackpct);
          if (give && wn < 2) begin
            waddr[wn] = mem_addr_o;
            wdat[wn]  = mem_wdata_o;
            wn++;
          end
          mem_ack_i  = give;
          stall_prev = !give;
          hold_addr  = mem_addr_o;
          hold_data  = mem_wdata_o;
        end else begin
          mem_ack_i  = 1'b0;
          stall_prev = 1'b0;
          if (!busy_o) busy_err++;
        end
      end
      check({tag, " R8 done seen"}, seen_done, seen_done, 1);
      check({tag, " R10 stall hold"}, hold_err == 0, hold_err, 0);
      check({tag, " R8 busy span"}, busy_err == 0, busy_err, 0);
      check({tag, " R4 write count"}, wn == 2, wn, 2);
      check({tag, " R4 low byte"}, waddr[0] == exp_sp && wdat[0] == pc[7:0],
            {waddr[0], wdat[0]}, {exp_sp, pc[7:0]});
      check({tag, " R4 high byte"}, waddr[1] == sp - 16'd1 && wdat[1] == pc[15:8],
            {waddr[1], wdat[1]}, {sp - 16'd1, pc[15:8]});
      check({tag, " R5 new sp"}, sp_o == exp_sp, sp_o, exp_sp);
      check({tag, " R3 R6 vector"}, pc_o == src_vec(sel), pc_o, src_vec(sel));
      check({tag, " R7 flag clear"}, flag_clr_o == src_mask(sel), flag_clr_o, src_mask(sel));
      check({tag, " R7 ime clear"}, ime_clr_o == 1'b1, ime_clr_o, 1);
      check({tag, " R8 cost"}, cyc_inc_o == 4'd3, cyc_inc_o, 3);
      // the core applies the effects
      ime_i   = 1'b0;
      iflag_i = iflag_i & ~flag_clr_o;
      @(negedge clk);
      check({tag, " R8 pulse ends"}, !done_o && cyc_inc_o == 4'd0 && !busy_o,
            {done_o, cyc_inc_o, busy_o}, 0);
      check({tag, " R7 clears end"}, !ime_clr_o && flag_clr_o == 8'h00,
            {ime_clr_o, flag_clr_o}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    ime_i = 1'b1; ien_i = 8'hFF; iflag_i = 8'h01;
    repeat (3) @(negedge clk);
    check("R9 reset outputs", !busy_o && !done_o && !mem_req_o,
          {busy_o, done_o, mem_req_o}, 0);
    ime_i = 1'b0; iflag_i = 8'h00;
    @(negedge clk);
    rst = 1'b0;

    run_case("R1 master off",        1'b0, 8'hFF, 8'hFF, 16'h1234, 16'hC000, 70, 8'h00);
    run_case("R2 lone lcd",          1'b1, 8'hFF, 8'h02, 16'h1234, 16'hC000, 70, 8'h00);
    run_case("R2 unmapped bits",     1'b1, 8'hFF, 8'hE8, 16'h1234, 16'hC000, 70, 8'h00);
    run_case("R2 flag not enabled",  1'b1, 8'h02, 8'h15, 16'h1234, 16'hC000, 70, 8'h00);
    run_case("R3 lcd beats timer",   1'b1, 8'hFF, 8'h06, 16'hBEEF, 16'hD000, 60, 8'h00);
    run_case("R3 all pending",       1'b1, 8'hFF, 8'h17, 16'h0102, 16'hFFFE, 100, 8'h00);
    run_case("R6 keypad only",       1'b1, 8'h10, 8'hFF, 16'h8001, 16'h4000, 40, 8'h00);
    run_case("R3 timer after vblank",1'b1, 8'hFF, 8'h04, 16'h2222, 16'h3000, 50, 8'h00);
    run_case("R5 sp wrap",           1'b1, 8'hFF, 8'h01, 16'hA55A, 16'h0001, 80, 8'h00);
    run_case("R11 late vblank",      1'b1, 8'hFF, 8'h04, 16'h7777, 16'h9000, 30, 8'h01);

    for (int i = 0; i < 40; i++) begin
      logic [7:0]  en_r;
      logic [7:0]  fl_r;
      logic        ime_r;
      logic [15:0] pc_r;
      logic [15:0] sp_r;
      int          pct;
      en_r  = 8'($urandom);
      fl_r  = 8'($urandom);
      ime_r = ($urandom_range(3) != 0);
      pc_r  = 16'($urandom);
      sp_r  = 16'($urandom);
      pct   = int'($urandom_range(100, 30));
      run_case("R2 R3 random", ime_r, en_r, fl_r, pc_r, sp_r, pct, 8'h00);
    end

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule